// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 level-sensitive interrupt sources and drives a single interrupt request line to a processor. Software programs one vector word per source and builds an enable mask through two command registers: one that only sets mask bits, one that only clears them. When arbitration is open and at least one enabled source is pending, the block latches the lowest-numbered such source. It records that source number and its vector, then raises the request line.

The processor services the interrupt by reading the vector register. This read returns the latched vector, acknowledges the interrupt and drops the request line. The current-source register tells the handler which source was taken, and reading it also clears it. Arbitration stays closed until software writes the end-of-interrupt register. Because sources are level-sensitive, a source that is still pending at that point raises the request again. Several system peripherals may be wired together onto one source input, which the integrator ORs outside the block.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the request line is low, the enable mask (read at byte offset 0x120) is zero and the current-source register (offset 0x108) reads zero.
- R2: A write to offset 0x120 ORs the written bits into the enable mask, and a read of 0x120 returns the mask; bit n of the mask enables source n.
- R3: A write to offset 0x124 clears each mask bit that is set in the written word and leaves the other bits unchanged.
- R4: With arbitration open, an enabled source that is high at a clock edge raises the request line after that edge and latches its number into 0x108 and its vector into 0x100. A source whose mask bit is clear never raises the request.
- R5: When several enabled sources are pending together, the lowest-numbered one is latched.
- R6: A read of offset 0x100 returns the latched vector and lowers the request line after the clock edge of the read. Writes to 0x100 leave its contents unchanged.
- R7: A read of 0x108 returns the latched source number, after which 0x108 reads zero.
- R8: Between the vector read and the end-of-interrupt write, the request line stays low whatever the sources do.
- R9: A write to offset 0x130 reopens arbitration, and an enabled source still high then raises the request line again.
- R10: The vector word of source n is read and written at byte offset 0x80 + 4·n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level-sensitive interrupt sources, bit n is source n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; side effects are applied at the clock edge |
| addr_i | input | AW | Byte address of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong arbitration state shows at the ports either as a request line that stays low while an enabled source is held high, or as a request line that rises inside the window between the vector read and the end-of-interrupt write. Both show one clock after the offending edge. A wrong winner or a stale latch shows in the very next read of 0x108 or 0x100, with the wrong number or vector. Mask corruption shows on the next read of 0x120, and also as a request that a source with a clear mask bit should not have raised.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [AW-1:0] A_VTAB = AW'(12'h080);
  localparam logic [AW-1:0] A_VTAB_END = AW'(12'h080 + 4 * NSRC);
  localparam logic [AW-1:0] A_VEC  = AW'(12'h100);
  localparam logic [AW-1:0] A_CUR  = AW'(12'h108);
  localparam logic [AW-1:0] A_ENA  = AW'(12'h120);
  localparam logic [AW-1:0] A_DIS  = AW'(12'h124);
  localparam logic [AW-1:0] A_EOI  = AW'(12'h130);

  typedef enum logic [1:0] {ST_OPEN, ST_HELD, ST_WAIT} st_t;

  st_t              st;
  logic [DW-1:0]    vtab [NSRC];
  logic [NSRC-1:0]  mask;
  logic [IW-1:0]    cur_src;
  logic [DW-1:0]    cur_vec;
  logic [NSRC-1:0]  pend;
  logic [IW-1:0]    win;

  wire hit_vtab = (addr_i >= A_VTAB) && (addr_i < A_VTAB_END);
  wire [AW-1:0] tab_off = addr_i - A_VTAB;
  wire [IW-1:0] tab_idx = IW'(tab_off >> 2);
  wire vec_rd = rd_en_i && (addr_i == A_VEC);
  wire cur_rd = rd_en_i && (addr_i == A_CUR);
  wire ena_wr = wr_en_i && (addr_i == A_ENA);
  wire dis_wr = wr_en_i && (addr_i == A_DIS);
  wire eoi_wr = wr_en_i && (addr_i == A_EOI);

  assign pend = src_i & mask;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) vtab[i] <= '0;
    end else if (wr_en_i && hit_vtab) begin
      vtab[tab_idx] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else if (ena_wr) mask <= mask | wdata_i[NSRC-1:0];
    else if (dis_wr) mask <= mask & ~wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_OPEN;
      irq_o   <= 1'b0;
      cur_src <= '0;
      cur_vec <= '0;
    end else begin
      if (cur_rd) cur_src <= '0;
      case (st)
        ST_OPEN: if (|pend) begin
          st      <= ST_HELD;
          irq_o   <= 1'b1;
          cur_src <= win;
          cur_vec <= vtab[win];
        end
        ST_HELD: if (eoi_wr) begin
          st    <= ST_OPEN;
          irq_o <= 1'b0;
        end else if (vec_rd) begin
          st    <= ST_WAIT;
          irq_o <= 1'b0;
        end
        ST_WAIT: if (eoi_wr) st <= ST_OPEN;
        default: st <= ST_OPEN;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_vtab) rdata_o = vtab[tab_idx];
    else begin
      case (addr_i)
        A_VEC:   rdata_o = cur_vec;
        A_CUR:   rdata_o = DW'(cur_src);
        A_ENA:   rdata_o = DW'(mask);
        default: rdata_o = '0;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !irq_o && mask == '0);

  assert_enable_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ena_wr |=> (mask & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0]));

  assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_wr && !ena_wr) |=> (mask & $past(wdata_i[NSRC-1:0])) == '0);

  assert_rise_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(src_i & mask)));

  assert_vec_read_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_o) |=> !irq_o);

  assert_quiet_until_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !eoi_wr) |=> !irq_o);

  assert_irq_only_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> st == ST_HELD);
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  localparam int NSRC = 32;
  localparam int DW = 32;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.NSRC(NSRC), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] vec_of(int n);
    return 32'hA000_0000 + 32'(n * 3);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    bus_rd(12'h120, d); check("R1 mask", d, 0);
    bus_rd(12'h108, d); check("R1 cur", d, 0);
  endtask

  task automatic t_vectors;
    logic [31:0] d;
    for (int i = 0; i < NSRC; i++) bus_wr(AW'(12'h080 + 4 * i), vec_of(i));
    bus_rd(12'h080, d); check("R10 vec0", d, vec_of(0));
    bus_rd(12'h0FC, d); check("R10 vec31", d, vec_of(31));
    bus_rd(12'h094, d); check("R10 vec5", d, vec_of(5));
  endtask

  task automatic t_mask;
    logic [31:0] d;
    bus_wr(12'h120, 32'h0000_00F0);
    bus_wr(12'h120, 32'h0000_0003);
    bus_rd(12'h120, d); check("R2 or-in", d, 32'h0000_00F3);
    bus_wr(12'h124, 32'h0000_0021);
    bus_rd(12'h120, d); check("R3 clear", d, 32'h0000_00D2);
  endtask

  task automatic t_masked_src;
    @(negedge clk); src = 32'h0000_0001;
    idle(3); check("R4 masked source no irq", 32'(irq), 0);
    src = '0;
  endtask

  task automatic t_single;
    logic [31:0] d;
    @(negedge clk); src = 32'h0000_0010;
    @(negedge clk); check("R4 irq raised", 32'(irq), 1);
    bus_rd(12'h108, d); check("R4 cur src", d, 4);
    bus_rd(12'h108, d); check("R7 cur cleared", d, 0);
    check("R7 irq kept", 32'(irq), 1);
    bus_rd(12'h100, d); check("R4 vector", d, vec_of(4));
    check("R6 irq dropped", 32'(irq), 0);
    bus_wr(12'h100, 32'h1234_5678);
    bus_rd(12'h100, d); check("R6 write ignored", d, vec_of(4));
    src = 32'h0000_0012;
    idle(3); check("R8 quiet before eoi", 32'(irq), 0);
    src = '0;
    bus_wr(12'h130, 0);
    idle(2); check("R9 no source no irq", 32'(irq), 0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    @(negedge clk); src = 32'h0000_00C2;
    @(negedge clk); check("R5 irq", 32'(irq), 1);
    bus_rd(12'h108, d); check("R5 lowest wins", d, 1);
    bus_rd(12'h100, d); check("R5 vector of 1", d, vec_of(1));
    src = 32'h0000_00C0;
    bus_wr(12'h130, 0);
    @(negedge clk); check("R9 re-raise", 32'(irq), 1);
    bus_rd(12'h108, d); check("R9 next source", d, 6);
    bus_rd(12'h100, d); check("R9 next vector", d, vec_of(6));
    src = '0;
    bus_wr(12'h130, 0);
    idle(2); check("R9 settled", 32'(irq), 0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_vectors();
        t_mask();
        t_masked_src();
        t_single();
        t_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule